// File: doc/BRIEF.md
# Adaptive Non-Overlap Half-Bridge Gate Sequencer

This block turns a single PWM command into the two switch enables of a half bridge: one for the high-side switch, one for the low-side switch. It never holds a fixed dead time. When the command changes, it first removes the enable of the switch that is conducting. It then waits for a digitized feedback flag before it enables the other switch. On a high command it waits for a flag that says the low-side gate has discharged. On a low command it waits for a flag that says the switch node has fallen.

The switch node is still watched while the low-side switch is enabled. If the node stays high for a programmable number of clock cycles, the low-side enable is withdrawn. A fault flag is then raised, and the bridge stays idle until the next rising edge of the command.

Two inputs override everything else and force the bridge idle for as long as they persist: a supply-ready input that is deasserted, and an active shutdown request. The PWM command passes through a two-stage synchronizer before it is used. All comparator flags are taken as synchronous single-bit inputs.

Top module: `gate_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `hs_en_o`, `ls_en_o` and `fault_o` are all 0.
- R2: When `supply_ok_i` is 0 at a rising clock edge, both enables are 0 after that edge, whatever `pwm_i` does. Once `supply_ok_i` returns to 1, the sequence restarts from the synchronized PWM level.
- R3: When the synchronized command goes from 0 to 1, `ls_en_o` drops first. `hs_en_o` becomes 1 only after an edge at which `ls_gate_low_i` is 1, and it stays 0 for as long as that flag is 0.
- R4: When the synchronized command goes from 1 to 0, `hs_en_o` drops first. `ls_en_o` becomes 1 only after an edge at which `sw_node_low_i` is 1, and it stays 0 for as long as that flag is 0.
- R5: `hs_en_o` and `ls_en_o` are never 1 in the same cycle.
- R6: `pwm_i` passes through two flops before it is used. A change of `pwm_i` ahead of edge k first changes a gate enable at edge k+2, which is the third rising edge counting edge k.
- R7: While `ls_en_o` is 1, if `sw_node_low_i` is 0 at FAULT_CYCLES consecutive rising edges, then at the last of those edges `ls_en_o` goes to 0 and `fault_o` goes to 1. A run of FAULT_CYCLES-1 edges causes no fault, and the count restarts from zero whenever the flag returns to 1.
- R8: After a fault, both enables stay 0 and `fault_o` stays 1 until the synchronized command has a rising edge. At that edge `fault_o` clears and the sequence continues as in R3.
- R9: While `shutdown_i` is 1, both enables and `fault_o` are 0 after each edge. Shutdown takes priority over a fault timeout that expires at the same edge. After release, the sequence restarts from the synchronized PWM level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Bias supply ready; 0 forces the bridge idle |
| shutdown_i | input | 1 | Shutdown request; 1 forces the bridge idle |
| pwm_i | input | 1 | PWM command, asynchronous; 1 requests high side |
| ls_gate_low_i | input | 1 | Low-side gate is below its turn-off level |
| sw_node_low_i | input | 1 | Switch node is below its low level |
| hs_en_o | output | 1 | High-side gate enable (registered) |
| ls_en_o | output | 1 | Low-side gate enable (registered) |
| fault_o | output | 1 | Switch-node fault latched (registered) |

## Verification
The case of interest is a collision between shutdown and the fault timeout. The bench lets the switch-node flag stay high for FAULT_CYCLES-1 edges while the low side is on. It then raises the shutdown request exactly before the edge at which the timeout would expire. After that edge, the enables and the fault flag must all read 0, which shows that shutdown won. After release, the low side must come back under the normal switch-node wait. The bench also checks the near-miss timeout, one edge short, against the exact expiry edge.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,  // both gates off, sequence restarts from PWM level
    ST_LS_ON    = 3'd1,  // low-side switch enabled
    ST_LS_DRAIN = 3'd2,  // waiting for low-side gate to discharge
    ST_HS_ON    = 3'd3,  // high-side switch enabled
    ST_SW_DRAIN = 3'd4,  // waiting for switch node to fall
    ST_LATCHED  = 3'd5   // switch-node fault, held until PWM rises
  } seq_state_e;

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic prev_q;
  logic synced;

  generate
    if (STAGES > 1) begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d_i};
      end
      assign synced = sh_q[STAGES-1];
    end else begin : g_single
      logic sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= 1'b0;
        else     sh_q <= d_i;
      end
      assign synced = sh_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= synced;
  end

  assign lvl_o  = synced;
  assign rise_o = synced & ~prev_q;

  AST_RISE_IMPLIES_HIGH: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !$past(prev_q) && prev_q) else $error("sync edge"); // R6
endmodule

// File: rtl/fault_timer.sv
module fault_timer #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic node_low_i,
  output logic expire_o
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;
  logic         running;

  assign running  = arm_i & ~node_low_i;
  assign expire_o = running && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !running || expire_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q < W'(LIMIT)) else $error("timer bound"); // R7
  AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (rst)
    node_low_i |=> cnt_q == '0) else $error("timer clear"); // R7
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import gate_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ready_i,
  input  logic       pwm_lvl_i,
  input  logic       pwm_rise_i,
  input  logic       lg_low_i,
  input  logic       sw_low_i,
  input  logic       expire_i,
  output seq_state_e state_o,
  output logic       hs_o,
  output logic       ls_o,
  output logic       fault_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!ready_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:     state_d = pwm_lvl_i ? ST_LS_DRAIN : ST_SW_DRAIN;
        ST_LS_DRAIN: if (!pwm_lvl_i)    state_d = ST_SW_DRAIN;
                     else if (lg_low_i) state_d = ST_HS_ON;
        ST_HS_ON:    if (!pwm_lvl_i)    state_d = ST_SW_DRAIN;
        ST_SW_DRAIN: if (pwm_lvl_i)     state_d = ST_LS_DRAIN;
                     else if (sw_low_i) state_d = ST_LS_ON;
        ST_LS_ON:    if (pwm_lvl_i)     state_d = ST_LS_DRAIN;
                     else if (expire_i) state_d = ST_LATCHED;
        ST_LATCHED:  if (pwm_rise_i)    state_d = ST_LS_DRAIN;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hs_o    <= 1'b0;
      ls_o    <= 1'b0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      hs_o    <= (state_d == ST_HS_ON);
      ls_o    <= (state_d == ST_LS_ON);
      fault_o <= (state_d == ST_LATCHED);
    end
  end

  assign state_o = state_q;

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LATCHED && !pwm_rise_i && ready_i) |=> state_q == ST_LATCHED)
    else $error("latch hold"); // R8
  AST_LATCH_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LATCHED && pwm_rise_i && ready_i) |=> state_q == ST_LS_DRAIN)
    else $error("latch exit"); // R8
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gate_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FAULT_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic shutdown_i,
  input  logic pwm_i,
  input  logic ls_gate_low_i,
  input  logic sw_node_low_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic fault_o
);
  logic       pwm_lvl, pwm_rise, expire, ready;
  seq_state_e state;

  assign ready = supply_ok_i & ~shutdown_i;

  pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pwm_i), .lvl_o(pwm_lvl), .rise_o(pwm_rise)
  );

  fault_timer #(.LIMIT(FAULT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .arm_i(state == ST_LS_ON),
    .node_low_i(sw_node_low_i), .expire_o(expire)
  );

  seq_fsm u_fsm (
    .clk(clk), .rst(rst), .ready_i(ready), .pwm_lvl_i(pwm_lvl),
    .pwm_rise_i(pwm_rise), .lg_low_i(ls_gate_low_i), .sw_low_i(sw_node_low_i),
    .expire_i(expire), .state_o(state), .hs_o(hs_en_o), .ls_o(ls_en_o),
    .fault_o(fault_o)
  );

  AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(hs_en_o && ls_en_o)) else $error("overlap"); // R5
  AST_SUPPLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !supply_ok_i |=> !hs_en_o && !ls_en_o) else $error("supply"); // R2
  AST_SHUTDOWN_IDLE: assert property (@(posedge clk) disable iff (rst)
    shutdown_i |=> !hs_en_o && !ls_en_o && !fault_o) else $error("shutdown"); // R9
  AST_HS_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_en_o) |-> $past(ls_gate_low_i)) else $error("hs early"); // R3
  AST_LS_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_en_o) |-> $past(sw_node_low_i)) else $error("ls early"); // R4
  AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> $past(ls_en_o) && !$past(sw_node_low_i)) else $error("fault src"); // R7
endmodule

// File: tb/gate_sequencer_tb_top.sv
module gate_sequencer_tb_top;
  localparam int N = 200;

  logic clk = 1'b0;
  logic rst, supply_ok, shutdown, pwm, lg_low, sw_low;
  logic hs_en, ls_en, fault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  hs;
    logic  ls;
    logic  flt;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  gate_sequencer #(.SYNC_STAGES(2), .FAULT_CYCLES(N)) dut_i (
    .clk(clk), .rst(rst), .supply_ok_i(supply_ok), .shutdown_i(shutdown),
    .pwm_i(pwm), .ls_gate_low_i(lg_low), .sw_node_low_i(sw_low),
    .hs_en_o(hs_en), .ls_en_o(ls_en), .fault_o(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic h, input logic l, input logic f, input string tag);
    exp_t e;
    e.hs = h; e.ls = l; e.flt = f; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      checks++;
      if (hs_en !== e.hs || ls_en !== e.ls || fault !== e.flt) begin
        errors++;
        $display("FAIL %s: got hs=%b ls=%b fault=%b expected hs=%b ls=%b fault=%b",
                 e.tag, hs_en, ls_en, fault, e.hs, e.ls, e.flt);
      end
    end
  end

  // R5 overlap watch on every cycle
  always @(negedge clk) begin
    if (!rst && hs_en && ls_en) begin
      errors++;
      $display("FAIL R5: got hs=1 ls=1 expected not both");
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; supply_ok = 1; shutdown = 0; pwm = 0; lg_low = 0; sw_low = 0;
    tick(3);
    expect_out(0, 0, 0, "R1 in reset");
    rst = 0;
    tick(1);
    expect_out(0, 0, 0, "R1 after release");
    tick(4);
    expect_out(0, 0, 0, "R4 waits for node flag");
    sw_low = 1; tick(1);
    expect_out(0, 1, 0, "R4 low side on");

    // rising command
    pwm = 1; tick(2);
    expect_out(0, 1, 0, "R6 no reaction at second edge");
    tick(1);
    expect_out(0, 0, 0, "R3 low side dropped");
    tick(5);
    expect_out(0, 0, 0, "R3 high side waits for gate flag");
    lg_low = 1; sw_low = 0; tick(1);
    expect_out(1, 0, 0, "R3 high side on");

    // falling command
    pwm = 0; tick(2);
    expect_out(1, 0, 0, "R6 high still on at second edge");
    tick(1);
    expect_out(0, 0, 0, "R4 high side dropped");
    tick(4);
    expect_out(0, 0, 0, "R4 low side waits for node flag");
    sw_low = 1; tick(1);
    expect_out(0, 1, 0, "R4 low side on again");

    // near-miss timeout then real timeout
    sw_low = 0; tick(N - 1);
    expect_out(0, 1, 0, "R7 one edge short");
    sw_low = 1; tick(1);
    expect_out(0, 1, 0, "R7 flag returns");
    sw_low = 0; tick(N - 1);
    expect_out(0, 1, 0, "R7 count restarted");
    tick(1);
    expect_out(0, 0, 1, "R7 fault at expiry");

    // fault hold until PWM rises
    sw_low = 1; tick(10);
    expect_out(0, 0, 1, "R8 held despite node low");
    pwm = 1; lg_low = 0; tick(3);
    expect_out(0, 0, 0, "R8 cleared on rising edge");
    lg_low = 1; tick(1);
    expect_out(1, 0, 0, "R8 high side resumes");

    // shutdown
    shutdown = 1; tick(1);
    expect_out(0, 0, 0, "R9 shutdown idles");
    pwm = 0; sw_low = 1; tick(6);
    expect_out(0, 0, 0, "R9 held with PWM low");
    pwm = 1; tick(6);
    expect_out(0, 0, 0, "R9 held with PWM high");
    shutdown = 0; tick(2);
    expect_out(1, 0, 0, "R9 resumes after release");

    // collision: shutdown at the edge of timeout expiry
    pwm = 0; sw_low = 1; tick(4);
    expect_out(0, 1, 0, "R4 low side for collision");
    sw_low = 0; tick(N - 1);
    expect_out(0, 1, 0, "R7 before collision");
    shutdown = 1; tick(1);
    expect_out(0, 0, 0, "R9 shutdown beats timeout");
    shutdown = 0; sw_low = 1; tick(2);
    expect_out(0, 1, 0, "R9 resume low side");

    // supply loss
    supply_ok = 0; tick(1);
    expect_out(0, 0, 0, "R2 supply low idles");
    pwm = 1; lg_low = 1; tick(6);
    expect_out(0, 0, 0, "R2 ignores PWM high");
    pwm = 0; tick(6);
    expect_out(0, 0, 0, "R2 ignores PWM low");
    supply_ok = 1; tick(2);
    expect_out(0, 1, 0, "R2 restart from PWM level");

    tick(2);
    wait (exp_q.size() == 0);
    #1;
    checks++; // R5 overlap watch counted as one check
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule